// File: doc/BRIEF.md
# Streaming Grouped-Repetition Pattern Matcher

This block scans a byte stream, one character per clock, for a fixed pattern made of a single leading character followed by a multi-character group that must repeat a bounded number of times, such as `d(abc){3}`. Every input byte is decoded into 256 one-hot lines. Each pattern position owns a single state flip-flop, and several positions may be active in the same cycle. Any group position may accept an inclusive character range instead of one character. In that case the range's decoded lines are ORed together into that position's one flip-flop.

The group can be entered from two places: the leading-character state, or the group's own completion state, so repetitions can follow each other with no gap. Each time the last group position fires, a repetition counter advances. A reset unit clears the counter whenever no group position is active, which means the consecutive group sequence was broken. Three counting variants are selected by parameters: exact count, bounded range (which also covers "at most" with a lower bound of one), and open-ended "at least". A registered one-cycle match pulse reports each qualifying repetition.

Top module: `rx_group_repeat_match`

## Requirements
- R1: A synchronous active-high `rst` clears every state flip-flop, the repetition count and `match_o`. A repetition in progress when reset is applied does not count after reset.
- R2: When the final group character of a qualifying repetition is sampled at clock edge k, `match_o` is high from edge k+1 until edge k+2 and low otherwise.
- R3: The first group position can only be entered directly after the leading character (`LEAD_CHAR`) or directly after a completed group. Group repetitions with no leading character never match.
- R4: With `MIN_REP == MAX_REP` and `AT_LEAST == 0`, a match occurs on the MIN_REP-th consecutive repetition. The count then returns to zero, so repetition MIN_REP+1 does not match and repetition 2*MIN_REP does. The count never exceeds MAX_REP.
- R5: An input character that belongs to no active group position breaks the sequence and clears the count. Later group repetitions are not counted until the leading character is seen again.
- R6: A group character that arrives out of order breaks the sequence the same way as an unrelated character.
- R7: The leading character arriving anywhere in the stream restarts the sequence. Counting resumes from one with the next completed group.
- R8: Group position i accepts any byte c with `GROUP_LO` byte i <= c <= `GROUP_HI` byte i, inclusive, where byte 0 is the most significant byte of each vector. A byte outside that range breaks the sequence.
- R9: With `MIN_REP < MAX_REP` and `AT_LEAST == 0`, every repetition whose count is from MIN_REP to MAX_REP matches. The count wraps to zero after MAX_REP.
- R10: With `AT_LEAST == 1`, every consecutive repetition from the MIN_REP-th onward matches, for as long as the sequence is unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. One character is consumed per rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| char_in | input | 8 | Input character for the current cycle. |
| match_o | output | 1 | One-cycle pulse for each qualifying repetition. |

## Verification
The bench feeds strings that sit on the count boundaries: one repetition past an exact count, where a design that saturates instead of wrapping would not match again at twice the count; and the last value inside a range. It breaks the group with a stray byte, with a misordered group byte, with a byte just outside a class range, and with a fresh leading character in the middle of the sequence. A design that reset only on unrelated bytes, or that treated the leading character as neutral, would report a match one repetition too early. Group repetitions with no leading character, a doubled leading character, and a reset pulse on the very byte that would complete a repetition are also applied, so that a design that lets the group enter on its own, or keeps its count through reset, produces a spurious pulse.

// File: rtl/rx_pkg.sv
package rx_pkg;

   localparam int unsigned NUM_LINES = 256;

   typedef logic [7:0]           char_t;
   typedef logic [NUM_LINES-1:0] line_vec_t;

   // Decoded-line mask for an inclusive character range lo..hi.
   function automatic line_vec_t class_mask(input char_t lo, input char_t hi);
      line_vec_t m;
      for (int k = 0; k < NUM_LINES; k++) begin
         m[k] = (k >= int'(lo)) && (k <= int'(hi));
      end
      return m;
   endfunction

endpackage

// File: rtl/rx_char_decode.sv
module rx_char_decode
   import rx_pkg::*;
(
   input  char_t     char_in,
   output line_vec_t lines_o
);
   for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      assign lines_o[k] = (char_in == char_t'(k));
   end
endmodule

// File: rtl/rx_group_chain.sv
module rx_group_chain #(
   parameter int unsigned GROUP_LEN = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 lead_hit,
   input  logic [GROUP_LEN-1:0] pos_hit,
   output logic [GROUP_LEN-1:0] grp_q,
   output logic                 inc,
   output logic                 rst_cnt
);
   localparam int unsigned LAST = GROUP_LEN - 1;

   logic lead_q;

   always_ff @(posedge clk) begin
      if (rst) lead_q <= 1'b0;
      else     lead_q <= lead_hit;
   end

   // The group entry is fed by the leading state OR the group's own completion.
   always_ff @(posedge clk) begin
      if (rst) grp_q[0] <= 1'b0;
      else     grp_q[0] <= pos_hit[0] & (lead_q | grp_q[LAST]);
   end

   for (genvar i = 1; i < GROUP_LEN; i++) begin : g_pos
      always_ff @(posedge clk) begin
         if (rst) grp_q[i] <= 1'b0;
         else     grp_q[i] <= pos_hit[i] & grp_q[i-1];
      end
   end

   assign inc     = grp_q[LAST];
   // No group state alive: the consecutive sequence is broken.
   assign rst_cnt = ~(|grp_q);
endmodule

// File: rtl/rx_rep_counter.sv
module rx_rep_counter #(
   parameter int unsigned MIN_REP  = 3,
   parameter int unsigned MAX_REP  = 3,
   parameter bit          AT_LEAST = 1'b0,
   localparam int unsigned CW      = $clog2(MAX_REP + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          rst_cnt,
   output logic [CW-1:0] cnt_q,
   output logic          match_q
);
   localparam logic [CW:0] MIN_V = (CW+1)'(MIN_REP);
   localparam logic [CW:0] MAX_V = (CW+1)'(MAX_REP);

   logic [CW:0]   cnt_plus;
   logic [CW-1:0] cnt_next;
   logic          in_range;

   assign cnt_plus = {1'b0, cnt_q} + (CW+1)'(1);

   if (AT_LEAST) begin : g_open
      // Saturate at the lower bound: every further repetition qualifies.
      assign cnt_next = (cnt_plus >= MIN_V) ? MIN_V[CW-1:0] : cnt_plus[CW-1:0];
      assign in_range = inc && (cnt_plus >= MIN_V);
   end else begin : g_bounded
      // Wrap to zero once the upper bound is reached.
      assign cnt_next = (cnt_plus == MAX_V) ? '0 : cnt_plus[CW-1:0];
      assign in_range = inc && (cnt_plus >= MIN_V) && (cnt_plus <= MAX_V);
   end

   always_ff @(posedge clk) begin
      if (rst || rst_cnt) cnt_q <= '0;
      else if (inc)       cnt_q <= cnt_next;
   end

   always_ff @(posedge clk) begin
      if (rst) match_q <= 1'b0;
      else     match_q <= in_range;
   end
endmodule

// File: rtl/rx_group_repeat_match.sv
module rx_group_repeat_match #(
   parameter logic [7:0]           LEAD_CHAR = "d",
   parameter int unsigned          GROUP_LEN = 3,
   parameter logic [8*GROUP_LEN-1:0] GROUP_LO = "abc",
   parameter logic [8*GROUP_LEN-1:0] GROUP_HI = "abc",
   parameter int unsigned          MIN_REP   = 3,
   parameter int unsigned          MAX_REP   = 3,
   parameter bit                   AT_LEAST  = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] char_in,
   output logic       match_o
);
   import rx_pkg::*;

   localparam int unsigned CNT_W = $clog2(MAX_REP + 1);

   if (GROUP_LEN < 1)       begin : g_err_len  $error("GROUP_LEN must be at least 1"); end
   if (MIN_REP < 1)         begin : g_err_min  $error("MIN_REP must be at least 1"); end
   if (MAX_REP < MIN_REP)   begin : g_err_max  $error("MAX_REP must not be below MIN_REP"); end
   if (AT_LEAST && (MAX_REP != MIN_REP)) begin : g_err_open
      $error("open-ended counting needs MAX_REP equal to MIN_REP");
   end

   line_vec_t            dec_lines;
   logic [GROUP_LEN-1:0] pos_hit;
   logic [GROUP_LEN-1:0] grp_q;
   logic                 inc;
   logic                 rst_cnt;
   logic [CNT_W-1:0]     rep_cnt;

   rx_char_decode i_decode (
      .char_in (char_in),
      .lines_o (dec_lines)
   );

   // Each position ORs the decoded lines of its range into one flip-flop input.
   for (genvar i = 0; i < GROUP_LEN; i++) begin : g_class
      localparam line_vec_t MASK = class_mask(GROUP_LO[8*(GROUP_LEN-1-i) +: 8],
                                              GROUP_HI[8*(GROUP_LEN-1-i) +: 8]);
      assign pos_hit[i] = |(dec_lines & MASK);
   end

   rx_group_chain #(.GROUP_LEN(GROUP_LEN)) i_chain (
      .clk      (clk),
      .rst      (rst),
      .lead_hit (dec_lines[LEAD_CHAR]),
      .pos_hit  (pos_hit),
      .grp_q    (grp_q),
      .inc      (inc),
      .rst_cnt  (rst_cnt)
   );

   rx_rep_counter #(
      .MIN_REP  (MIN_REP),
      .MAX_REP  (MAX_REP),
      .AT_LEAST (AT_LEAST)
   ) i_counter (
      .clk     (clk),
      .rst     (rst),
      .inc     (inc),
      .rst_cnt (rst_cnt),
      .cnt_q   (rep_cnt),
      .match_q (match_o)
   );
endmodule

// File: rtl/rx_group_repeat_match_chk.sv
module rx_group_repeat_match_chk #(
   parameter int unsigned GLEN    = 3,
   parameter int unsigned CW      = 2,
   parameter int unsigned MAX_REP = 3
) (
   input logic            clk,
   input logic            rst,
   input logic [255:0]    dec,
   input logic [GLEN-1:0] grp,
   input logic            inc,
   input logic            rst_cnt,
   input logic [CW-1:0]   cnt,
   input logic            match
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (cnt == '0) && !match);

   p_match_after_inc_r2: assert property (@(posedge clk) disable iff (rst)
      match |-> $past(inc));

   p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(MAX_REP));

   p_break_clears_r5: assert property (@(posedge clk) disable iff (rst)
      rst_cnt |=> (cnt == '0));

   p_decode_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot(dec));

   for (genvar i = 1; i < GLEN; i++) begin : g_order
      p_group_order_r6: assert property (@(posedge clk) disable iff (rst)
         grp[i] |-> $past(grp[i-1]));
   end
endmodule

bind rx_group_repeat_match rx_group_repeat_match_chk #(
   .GLEN    (GROUP_LEN),
   .CW      (CNT_W),
   .MAX_REP (MAX_REP)
) i_chk (
   .clk     (clk),
   .rst     (rst),
   .dec     (dec_lines),
   .grp     (grp_q),
   .inc     (inc),
   .rst_cnt (rst_cnt),
   .cnt     (rep_cnt),
   .match   (match_o)
);

// File: tb/test_rx_group_repeat_match.sv
module test_rx_group_repeat_match;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] ch  = 8'h00;
   logic       m_exact, m_range, m_open;
   int         n_checks = 0;
   int         n_fail   = 0;
   bit         done     = 1'b0;

   always #5 clk = ~clk;

   // Exact count of 3 repetitions of "abc" after 'd'.
   rx_group_repeat_match i_rx_group_repeat_match (
      .clk(clk), .rst(rst), .char_in(ch), .match_o(m_exact));

   // Bounded range 2..3 of "a[0-9]c" after 'd'.
   rx_group_repeat_match #(
      .GROUP_LO("a0c"), .GROUP_HI("a9c"), .MIN_REP(2), .MAX_REP(3)
   ) i_range (.clk(clk), .rst(rst), .char_in(ch), .match_o(m_range));

   // Two or more repetitions of "abc" after 'd'.
   rx_group_repeat_match #(
      .MIN_REP(2), .MAX_REP(2), .AT_LEAST(1'b1)
   ) i_open (.clk(clk), .rst(rst), .char_in(ch), .match_o(m_open));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   function automatic logic pick(input int which);
      case (which)
         0:       return m_exact;
         1:       return m_range;
         default: return m_open;
      endcase
   endfunction

   // Drive a string; '^' in mask marks the characters that complete a match.
   // The match for character j is sampled at the falling edge two cycles later.
   task automatic run_stream(input string req, input string s, input string mask,
                             input int which, input int rst_at);
      int n = s.len();
      for (int i = 0; i < n + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            logic exp = (i - 2 < mask.len()) && (mask[i-2] == 8'h5E);
            check(req, $sformatf("'%s' pos %0d", s, i - 2), pick(which), exp);
         end
         ch  = (i < n) ? s[i] : 8'h00;
         rst = (i == rst_at);
      end
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      check("R1", "exact after reset", m_exact, 1'b0);
      check("R1", "range after reset", m_range, 1'b0);
      check("R1", "open after reset",  m_open,  1'b0);
   endtask

   task automatic t_exact_basic();   run_stream("R2", "dabcabcabcz", ".........^.", 0, -1); endtask
   task automatic t_exact_wrap();    run_stream("R4", "dabcabcabcabcabcabc", ".........^........^", 0, -1); endtask
   task automatic t_no_lead();       run_stream("R3", "abcabcabcabc", "", 0, -1); endtask
   task automatic t_double_lead();   run_stream("R3", "ddabcabcabc", "..........^", 0, -1); endtask
   task automatic t_stray_char();    run_stream("R5", "dabcabzabcabc", "", 0, -1); endtask
   task automatic t_misorder();      run_stream("R6", "dabcacbabcabc", "", 0, -1); endtask
   task automatic t_lead_restart();  run_stream("R7", "dabcdabcabcabc", ".............^", 0, -1); endtask
   task automatic t_mid_reset();     run_stream("R1", "dabcabcabcabc", "", 0, 6); endtask
   task automatic t_range_walk();    run_stream("R9", "da5ca9ca0ca1c", "......^..^...", 1, -1); endtask
   task automatic t_range_edges();   run_stream("R8", "da0ca9c", "......^", 1, -1); endtask
   task automatic t_range_outside(); run_stream("R8", "da5ca:ca5ca5c", "", 1, -1); endtask
   task automatic t_open_run();      run_stream("R10", "dabcabcabcabcz", "......^..^..^.", 2, -1); endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_exact_basic();
      t_exact_wrap();
      t_no_lead();
      t_double_lead();
      t_stray_char();
      t_misorder();
      t_lead_restart();
      t_mid_reset();
      t_range_walk();
      t_range_edges();
      t_range_outside();
      t_open_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule